// File: doc/BRIEF.md
# UART Flash Upgrade Receiver

This block runs the device side of a firmware upgrade that arrives one byte at a time over a UART link. A start pulse makes it announce readiness to the host. It then collects a 32-bit image length and a 32-bit flash offset, answering every header byte with an acknowledgement code. After the header it takes image bytes one by one. Each byte goes to the flash write port at the offset plus the byte's zero-based index. The block acknowledges a byte only once the flash has reported that the write completed.

The acknowledgement code tells the host which phase the block is in. The host sends the next byte only after it sees the acknowledgement for the previous one. A byte that arrives while the block is still busy with an earlier one is discarded and recorded in a sticky error flag. The UART serializer, flash erase and any integrity check sit outside this block.

Top module: `fw_upgrade_rx`

## Requirements
- R1: After reset, tx_req, flash_req, busy, done and overrun are all 0.
- R2: A start pulse while idle transmits the ready code 0x01 and raises busy; overrun is cleared at the same time.
- R3: The first four bytes received after the ready code form the image length, most significant byte first; each is acknowledged with 0x03.
- R4: The next four bytes form the flash offset, most significant byte first; each is acknowledged with 0x04.
- R5: Each image byte causes exactly one flash write carrying that byte, at address (offset + index) modulo 2^ADDR_W, where the index counts from zero. flash_req, flash_addr and flash_data stay unchanged until flash_done.
- R6: Each image byte is acknowledged with 0x02, exactly once, and never while its flash write is pending.
- R7: An acknowledgement byte is handed over on a cycle with tx_req high and tx_busy low. While tx_busy is high, tx_req stays high and tx_byte stays stable.
- R8: When the acknowledgement of the last image byte has been handed over, done goes to 1 and busy to 0. Further received bytes are then ignored: no write, no acknowledgement.
- R9: A length of zero sets done once the fourth offset acknowledgement has been handed over, and no flash write occurs.
- R10: A byte received while a flash write or an acknowledgement is outstanding sets overrun, which stays 1. The byte is neither written nor acknowledged, and the image index does not advance.
- R11: A start pulse in the done state returns the block to idle (done 0, busy 0). A start pulse during a transfer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a session (idle) or return to idle (done) |
| rx_valid | input | 1 | One-cycle strobe: a received byte is on rx_byte |
| rx_byte | input | 8 | Received byte |
| tx_req | output | 1 | A byte for the host is waiting on tx_byte |
| tx_byte | output | 8 | Byte to transmit |
| tx_busy | input | 1 | Serializer cannot take a byte this cycle |
| flash_req | output | 1 | Flash write requested, held until flash_done |
| flash_addr | output | ADDR_W | Flash byte address |
| flash_data | output | 8 | Flash write data |
| flash_done | input | 1 | Flash write completed |
| busy | output | 1 | A session is in progress |
| done | output | 1 | All image bytes written and acknowledged |
| overrun | output | 1 | Sticky: a byte arrived while the block was not ready |

## Verification
The hardest situation to reach from the ports is a byte that arrives in the middle of a flash write. A well-behaved host never causes it, because it waits for each acknowledgement. The bench stretches the flash model's write latency over several cycles and pushes a second byte while flash_req is still high. It then checks the sticky flag, that no extra write or acknowledgement appears, and that the next legitimate byte lands at index one. Serializer backpressure is reached by holding tx_busy before the start pulse, so the ready code stays pending for several cycles before it is released.

// File: rtl/fwu_pkg.sv
// Shared types and constants for the firmware upgrade receiver.
// Assumes header fields are HDR_BYTES bytes long and sent MSB first.
package fwu_pkg;
    localparam int HDR_BYTES = 4;
    localparam int HDR_W     = 8 * HDR_BYTES;

    localparam logic [7:0] CODE_READY = 8'h01;
    localparam logic [7:0] CODE_DATA  = 8'h02;
    localparam logic [7:0] CODE_LEN   = 8'h03;
    localparam logic [7:0] CODE_OFS   = 8'h04;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACKW,
        ST_RXW,
        ST_WRW,
        ST_DONE
    } fwu_state_e;

    typedef enum logic [1:0] {
        PH_LEN,
        PH_OFS,
        PH_DATA
    } fwu_phase_e;
endpackage

// File: rtl/fwu_field_shift.sv
// Header field collector: shifts bytes in from the right, so the first
// byte received ends up most significant. Assumes BYTES >= 2.
module fwu_field_shift #(
    parameter int BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               shift,
    input  logic [7:0]         din,
    output logic [8*BYTES-1:0] value
);
    localparam int W = 8 * BYTES;

    // Clear at session start, otherwise append one byte per shift.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            value <= '0;
        end else if (shift) begin
            value <= {value[W-9:0], din};
        end
    end
endmodule

// File: rtl/fwu_ack_tx.sv
// One-entry transmit holder. A loaded code is offered on tx_req until the
// serializer accepts it (tx_busy low). Assumes load never coincides with
// a pending code; the controller guarantees that by its state sequence.
module fwu_ack_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] code,
    input  logic       tx_busy,
    output logic       tx_req,
    output logic [7:0] tx_byte,
    output logic       sent
);
    logic       pending;
    logic [7:0] code_q;

    assign tx_req  = pending;
    assign tx_byte = code_q;
    assign sent    = pending && !tx_busy;

    // Hold the code until the serializer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            code_q  <= 8'h00;
        end else if (load) begin
            pending <= 1'b1;
            code_q  <= code;
        end else if (sent) begin
            pending <= 1'b0;
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && tx_busy) |=> (tx_req && $stable(tx_byte))); // R7
endmodule

// File: rtl/fwu_flash_wr.sv
// Flash write port: latches address and data on launch and holds the
// request until flash_done. Assumes flash_done is only asserted while a
// request is outstanding; wr_fin marks the completing cycle.
module fwu_flash_wr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [7:0]        data_in,
    input  logic              flash_done,
    output logic              flash_req,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [7:0]        flash_data,
    output logic              wr_fin
);
    assign wr_fin = flash_req && flash_done;

    // Request register with captured address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flash_req  <= 1'b0;
            flash_addr <= '0;
            flash_data <= 8'h00;
        end else if (launch) begin
            flash_req  <= 1'b1;
            flash_addr <= addr_in;
            flash_data <= data_in;
        end else if (wr_fin) begin
            flash_req  <= 1'b0;
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_req && !flash_done) |=>
        (flash_req && $stable(flash_addr) && $stable(flash_data))); // R5
endmodule

// File: rtl/fw_upgrade_rx.sv
// Firmware upgrade receiver controller. Sequences ready code, length and
// offset headers, then image bytes, each written to flash before its
// acknowledgement. Assumes the host waits for each acknowledgement and
// that ADDR_W is no wider than the header field.
module fw_upgrade_rx
    import fwu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              tx_req,
    output logic [7:0]        tx_byte,
    input  logic              tx_busy,
    output logic              flash_req,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [7:0]        flash_data,
    input  logic              flash_done,
    output logic              busy,
    output logic              done,
    output logic              overrun
);
    localparam int CNT_W = $clog2(HDR_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HDR_BYTES - 1);

    fwu_state_e       state;
    fwu_phase_e       phase;
    logic [CNT_W-1:0] hdr_cnt;
    logic [HDR_W-1:0] idx;
    logic [HDR_W-1:0] img_len;
    logic [HDR_W-1:0] img_ofs;
    logic [HDR_W-1:0] addr_sum;
    logic             begin_sess;
    logic             accept;
    logic             ack_load;
    logic [7:0]       ack_code;
    logic             ack_sent;
    logic             wr_fin;
    logic             ovr_q;

    assign begin_sess = (state == ST_IDLE) && start;
    assign accept     = (state == ST_RXW) && rx_valid;
    assign addr_sum   = img_ofs + idx;
    assign busy       = (state != ST_IDLE) && (state != ST_DONE);
    assign done       = (state == ST_DONE);
    assign overrun    = ovr_q;

    // Pick the acknowledgement code for the event of this cycle.
    always_comb begin
        ack_load = 1'b0;
        ack_code = CODE_READY;
        if (begin_sess) begin
            ack_load = 1'b1;
        end else if (accept && phase == PH_LEN) begin
            ack_load = 1'b1;
            ack_code = CODE_LEN;
        end else if (accept && phase == PH_OFS) begin
            ack_load = 1'b1;
            ack_code = CODE_OFS;
        end else if (wr_fin) begin
            ack_load = 1'b1;
            ack_code = CODE_DATA;
        end
    end

    fwu_field_shift #(.BYTES(HDR_BYTES)) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (begin_sess),
        .shift (accept && phase == PH_LEN),
        .din   (rx_byte),
        .value (img_len)
    );

    fwu_field_shift #(.BYTES(HDR_BYTES)) u_ofs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (begin_sess),
        .shift (accept && phase == PH_OFS),
        .din   (rx_byte),
        .value (img_ofs)
    );

    fwu_ack_tx u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ack_load),
        .code    (ack_code),
        .tx_busy (tx_busy),
        .tx_req  (tx_req),
        .tx_byte (tx_byte),
        .sent    (ack_sent)
    );

    fwu_flash_wr #(.ADDR_W(ADDR_W)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (accept && phase == PH_DATA),
        .addr_in    (addr_sum[ADDR_W-1:0]),
        .data_in    (rx_byte),
        .flash_done (flash_done),
        .flash_req  (flash_req),
        .flash_addr (flash_addr),
        .flash_data (flash_data),
        .wr_fin     (wr_fin)
    );

    // Session sequencer: phase, header byte count and image index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= PH_LEN;
            hdr_cnt <= '0;
            idx     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_ACKW;
                        phase   <= PH_LEN;
                        hdr_cnt <= '0;
                        idx     <= '0;
                    end
                end
                ST_ACKW: begin
                    if (ack_sent) begin
                        if (phase == PH_DATA && idx == img_len) begin
                            state <= ST_DONE;
                        end else begin
                            state <= ST_RXW;
                        end
                    end
                end
                ST_RXW: begin
                    if (rx_valid) begin
                        if (phase == PH_DATA) begin
                            state <= ST_WRW;
                        end else begin
                            state   <= ST_ACKW;
                            hdr_cnt <= (hdr_cnt == CNT_LAST) ? '0 : hdr_cnt + 1'b1;
                            if (hdr_cnt == CNT_LAST) begin
                                phase <= (phase == PH_LEN) ? PH_OFS : PH_DATA;
                            end
                        end
                    end
                end
                ST_WRW: begin
                    if (wr_fin) begin
                        idx   <= idx + HDR_W'(1);
                        state <= ST_ACKW;
                    end
                end
                ST_DONE: begin
                    if (start) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Sticky overrun: byte seen while a write or acknowledgement is open.
    always_ff @(posedge clk) begin
        if (!rst_n || begin_sess) begin
            ovr_q <= 1'b0;
        end else if (rx_valid && (state == ST_ACKW || state == ST_WRW)) begin
            ovr_q <= 1'b1;
        end
    end

    AST_NO_ACK_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_req && tx_req)); // R6
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!flash_req && !tx_req && !busy)); // R8
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase == PH_DATA) |-> (idx <= img_len)); // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !start) |=> overrun); // R10
endmodule

// File: tb/fw_upgrade_rx_tb.sv
`timescale 1ns/1ps
module fw_upgrade_rx_tb;
    localparam int ADDR_W = 32;
    localparam int LAT    = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_byte = 8'h00;
    logic              tx_req;
    logic [7:0]        tx_byte;
    logic              tx_busy = 1'b0;
    logic              flash_req;
    logic [ADDR_W-1:0] flash_addr;
    logic [7:0]        flash_data;
    logic              flash_done = 1'b0;
    logic              busy;
    logic              done;
    logic              overrun;

    int checks = 0;
    int fails  = 0;

    logic [7:0]        ack_log [0:255];
    int                ack_n = 0;
    int                ack_in_write = 0;
    logic [ADDR_W-1:0] wr_addr [0:63];
    logic [7:0]        wr_data [0:63];
    int                wr_n = 0;
    int                lat_cnt = 0;

    always #2 clk = ~clk;

    fw_upgrade_rx #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_req(tx_req), .tx_byte(tx_byte),
        .tx_busy(tx_busy), .flash_req(flash_req), .flash_addr(flash_addr),
        .flash_data(flash_data), .flash_done(flash_done), .busy(busy),
        .done(done), .overrun(overrun)
    );

    // Serializer and flash models, sampled 1 ns after the falling edge.
    always @(negedge clk) begin
        #1;
        if (tx_req && !tx_busy) begin
            if (ack_n < 256) ack_log[ack_n] = tx_byte;
            ack_n = ack_n + 1;
            if (flash_req) ack_in_write = ack_in_write + 1;
        end
        if (flash_done) begin
            flash_done = 1'b0;
            lat_cnt = 0;
        end else if (flash_req) begin
            lat_cnt = lat_cnt + 1;
            if (lat_cnt == LAT) begin
                flash_done = 1'b1;
                if (wr_n < 64) begin
                    wr_addr[wr_n] = flash_addr;
                    wr_data[wr_n] = flash_data;
                end
                wr_n = wr_n + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic wait_acks(input int n);
        while (ack_n < n) @(negedge clk);
    endtask

    // Start a session and check the ready code.
    task automatic open_session();
        int base;
        base = ack_n;
        pulse_start();
        wait_acks(base + 1);
        check(ack_log[base] == 8'h01, "R2", "ready code", ack_log[base], 8'h01);
        check(busy == 1'b1, "R2", "busy after start", busy, 1);
    endtask

    // Send length and offset, MSB first, checking the header codes.
    task automatic send_header(input logic [31:0] len, input logic [31:0] ofs);
        for (int i = 0; i < 4; i++) begin
            send(len[31-8*i -: 8]);
            wait_acks(ack_n + 1);
            check(ack_log[ack_n-1] == 8'h03, "R3", "length ack", ack_log[ack_n-1], 8'h03);
        end
        for (int i = 0; i < 4; i++) begin
            send(ofs[31-8*i -: 8]);
            wait_acks(ack_n + 1);
            check(ack_log[ack_n-1] == 8'h04, "R4", "offset ack", ack_log[ack_n-1], 8'h04);
        end
    endtask

    // Send one image byte and check its write and acknowledgement.
    task automatic send_image(input logic [7:0] d, input logic [31:0] addr);
        int a0, w0;
        a0 = ack_n; w0 = wr_n;
        send(d);
        repeat (2) @(negedge clk);
        check(flash_req == 1'b1 && ack_n == a0, "R6", "no ack while write pending", ack_n, a0);
        wait_acks(a0 + 1);
        check(ack_log[a0] == 8'h02, "R6", "data ack", ack_log[a0], 8'h02);
        check(wr_n == w0 + 1, "R5", "one write per byte", wr_n, w0 + 1);
        check(wr_addr[w0] == addr, "R5", "write address", wr_addr[w0], addr);
        check(wr_data[w0] == d, "R5", "write data", wr_data[w0], d);
    endtask

    task automatic test_reset();
        check(tx_req == 0 && flash_req == 0, "R1", "requests after reset", {tx_req, flash_req}, 0);
        check(busy == 0 && done == 0 && overrun == 0, "R1", "status after reset",
              {busy, done, overrun}, 0);
    endtask

    task automatic test_normal();
        int a0;
        open_session();
        send(8'h00);
        wait_acks(ack_n + 1);
        a0 = ack_n;
        pulse_start();
        repeat (3) @(negedge clk);
        check(ack_n == a0 && busy == 1, "R11", "start during transfer ignored", ack_n, a0);
        for (int i = 1; i < 4; i++) begin
            send(i == 3 ? 8'h03 : 8'h00);
            wait_acks(ack_n + 1);
            check(ack_log[ack_n-1] == 8'h03, "R3", "length ack", ack_log[ack_n-1], 8'h03);
        end
        for (int i = 0; i < 4; i++) begin
            send(i == 2 ? 8'h10 : (i == 3 ? 8'hF0 : 8'h00));
            wait_acks(ack_n + 1);
            check(ack_log[ack_n-1] == 8'h04, "R4", "offset ack", ack_log[ack_n-1], 8'h04);
        end
        send_image(8'hA1, 32'h0000_10F0);
        check(done == 0, "R8", "not done early", done, 0);
        send_image(8'hB2, 32'h0000_10F1);
        send_image(8'hC3, 32'h0000_10F2);
        check(done == 1 && busy == 0, "R8", "done after last ack", {done, busy}, 2'b10);
    endtask

    task automatic test_ignore_and_idle();
        int a0, w0;
        a0 = ack_n; w0 = wr_n;
        send(8'h77);
        repeat (LAT + 4) @(negedge clk);
        check(ack_n == a0 && wr_n == w0 && done == 1, "R8", "byte ignored when done",
              ack_n, a0);
        pulse_start();
        @(negedge clk);
        check(done == 0 && busy == 0 && tx_req == 0, "R11", "start in done returns to idle",
              {done, busy, tx_req}, 0);
    endtask

    task automatic test_wrap();
        open_session();
        send_header(32'd2, 32'hFFFF_FFFF);
        send_image(8'h5A, 32'hFFFF_FFFF);
        send_image(8'hA5, 32'h0000_0000);
        check(done == 1, "R8", "done after wrap image", done, 1);
        pulse_start();
    endtask

    task automatic test_zero_backpressure();
        int a0, w0;
        a0 = ack_n; w0 = wr_n;
        @(negedge clk); tx_busy = 1'b1;
        pulse_start();
        repeat (4) @(negedge clk);
        check(tx_req == 1 && tx_byte == 8'h01 && ack_n == a0, "R7", "held under busy",
              {tx_req, tx_byte}, {1'b1, 8'h01});
        tx_busy = 1'b0;
        repeat (3) @(negedge clk);
        check(ack_n == a0 + 1 && tx_req == 0, "R7", "one handover after release", ack_n, a0 + 1);
        check(ack_log[a0] == 8'h01, "R2", "ready code after busy", ack_log[a0], 8'h01);
        send_header(32'd0, 32'h0000_0055);
        check(done == 1 && wr_n == w0, "R9", "zero length done, no write", {done, wr_n}, {1'b1, w0});
        pulse_start();
    endtask

    task automatic test_overrun();
        int a0, w0;
        open_session();
        send_header(32'd2, 32'h0000_0200);
        a0 = ack_n; w0 = wr_n;
        send(8'h11);
        send(8'h99);
        check(overrun == 1, "R10", "overrun set", overrun, 1);
        wait_acks(a0 + 1);
        repeat (LAT + 4) @(negedge clk);
        check(ack_n == a0 + 1 && wr_n == w0 + 1, "R10", "extra byte discarded", wr_n, w0 + 1);
        check(wr_data[w0] == 8'h11, "R10", "first byte written", wr_data[w0], 8'h11);
        send_image(8'h22, 32'h0000_0201);
        check(done == 1 && overrun == 1, "R10", "overrun sticky", overrun, 1);
        pulse_start();
        check(overrun == 1, "R10", "still set in idle", overrun, 1);
        open_session();
        check(overrun == 0, "R2", "start clears overrun", overrun, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_normal();
        test_ignore_and_idle();
        test_wrap();
        test_zero_backpressure();
        test_overrun();
        check(ack_in_write == 0, "R6", "acks during writes", ack_in_write, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks = checks + 1;
        fails = fails + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule